// File: doc/BRIEF.md
# Rotating Angle Generator

This block drives one channel's 16-bit output angle so that it turns on its own at a programmed signed rate. The angle is the top part of a phase accumulator. On every time tick the accumulator adds the rate word, so the angle can move in steps smaller than one output LSB. Negative rates turn the angle backwards, and the angle wraps modulo 2^16 in both directions.

There are two modes. In continuous mode the angle keeps turning until rotation is halted or a new angle is written. In target mode rotation ends on the tick that would reach or pass the programmed stop angle, moving in the direction of travel and with wrap allowed. The angle is then set exactly to the stop value and the completion flag rises. After a halt or a completion, a new start continues from the present angle.

The rate word is a 16-bit two's-complement number whose LSB stands for 0.15 degrees per second. Its magnitude is limited to 32640 (7F80h), which is 13.6 rev/s. The period of the time tick is chosen so that one rate LSB per tick matches that scale. Bus decoding and analog conversion sit outside this block, and one instance is used per channel.

Top module: `rotgen`

## Requirements
- R1: After reset the angle output is 0000h and the completion flag is 1.
- R2: A load pulse sets the angle output to the value on the load-angle input at the next clock edge, with the fractional bits cleared. It ends any rotation (completion flag 1). A load has priority over halt, start and tick in the same cycle.
- R3: A start pulse, when no load or halt is present, clears the completion flag at the next edge. It does not move the angle in that cycle. Halt has priority over start.
- R4: While rotating, each tick adds the rate to a 24-bit accumulator. The accumulator holds the angle in bits 23:8 and a fraction in bits 7:0, so a rate of 0100h advances the angle by one LSB per tick and 0080h advances it by one LSB every two ticks.
- R5: A negative rate (two's complement) moves the angle downward, and the angle wraps from 0000h to FFFFh.
- R6: Rates above +32640 are treated as +32640, and rates below −32640 as −32640.
- R7: With the mode input at 1 (continuous), the angle wraps freely and the completion flag stays 0 while ticks arrive.
- R8: With the mode input at 0 (target), the tick whose step would reach or cross the stop angle in the direction of rotation sets the angle to exactly the stop angle and sets the completion flag to 1. This includes a crossing through the 0000h/FFFFh wrap.
- R9: A halt pulse (when no load is present) sets the completion flag to 1 and freezes the angle. Later ticks do not move it.
- R10: A start after a halt or a completion continues from the present angle.
- R11: While the completion flag is 1, ticks leave the angle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Periodic time tick, one cycle wide |
| rate_i | input | 16 | Signed rate, LSB = 0.15 deg/s |
| stop_angle_i | input | 16 | Target angle for target mode |
| cont_mode_i | input | 1 | 1 = continuous, 0 = end at target |
| start_i | input | 1 | Start rotation pulse |
| halt_i | input | 1 | Halt rotation pulse |
| load_i | input | 1 | New angle written pulse |
| load_angle_i | input | 16 | Angle value taken on load |
| angle_o | output | 16 | Current angle |
| done_o | output | 1 | 1 = not rotating / finished, 0 = rotating |

## Verification
Every input is sampled at a rising edge, and both outputs come from registers. Each command and each tick is therefore visible on `angle_o` and `done_o` exactly one clock after the edge that samples it. The angle-moving tick and the completion flag both appear in that same cycle. The bench drives each pulse for one cycle starting at a falling edge and checks the outputs at the following falling edge, so every check looks at the state one register stage after its stimulus. The expected angles are worked out by hand from the accumulator arithmetic: wrap points, fractional carries, saturated rates and the exact clamp tick.

// File: rtl/rotgen_pkg.sv
package rotgen_pkg;

    // Decoded per-cycle operation for the angle datapath, highest priority first.
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_HALT  = 3'd2,
        OP_START = 3'd3,
        OP_STEP  = 3'd4
    } rot_op_e;

    // Request bundle seen by the decoder.
    typedef struct packed {
        logic load;
        logic halt;
        logic start;
        logic tick;
    } rot_req_t;

    // Full-scale rate magnitude: 13.6 rev/s at 0.15 deg/s per LSB.
    localparam int RATE_LIMIT_DEF = 32640;

    function automatic rot_op_e decode_op(rot_req_t r, logic running);
        if (r.load)                 return OP_LOAD;
        else if (r.halt)            return OP_HALT;
        else if (r.start)           return OP_START;
        else if (r.tick && running) return OP_STEP;
        else                        return OP_IDLE;
    endfunction

endpackage

// File: rtl/rotgen_rate_sat.sv
module rotgen_rate_sat
    import rotgen_pkg::*;
#(
    parameter int RATE_W     = 16,
    parameter int ACC_W      = 24,
    parameter int RATE_LIMIT = RATE_LIMIT_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [RATE_W-1:0]       rate_i,
    output logic [ACC_W-1:0]        step_o,
    output logic [ACC_W-1:0]        mag_o
);
    localparam int EXT_W = ACC_W - RATE_W;
    localparam logic signed [RATE_W-1:0] HI_LIM = RATE_W'(RATE_LIMIT);
    localparam logic signed [RATE_W-1:0] LO_LIM = -HI_LIM;

    logic signed [RATE_W-1:0] raw;
    logic signed [RATE_W-1:0] sat;
    logic        [RATE_W-1:0] sat_mag;

    assign raw = rate_i;

    always_comb begin
        if (raw > HI_LIM)      sat = HI_LIM;
        else if (raw < LO_LIM) sat = LO_LIM;
        else                   sat = raw;
    end

    assign sat_mag = sat[RATE_W-1] ? (~sat + 1'b1) : sat;
    assign step_o  = {{EXT_W{sat[RATE_W-1]}}, sat};
    assign mag_o   = {{EXT_W{1'b0}}, sat_mag};

    // R6: the step applied never exceeds the rate limit
    p_rate_bound_r6: assert property (@(posedge clk) disable iff (rst)
        mag_o <= ACC_W'(RATE_LIMIT));

endmodule

// File: rtl/rotgen_stop_det.sv
module rotgen_stop_det #(
    parameter int ANG_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic [ANG_W+FRAC_W-1:0] acc_i,
    input  logic [ANG_W+FRAC_W-1:0] step_i,
    input  logic [ANG_W+FRAC_W-1:0] mag_i,
    input  logic [ANG_W-1:0]        stop_angle_i,
    output logic                    hit_o
);
    localparam int ACC_W = ANG_W + FRAC_W;

    logic [ACC_W-1:0] target;
    logic [ACC_W-1:0] dist_up;
    logic [ACC_W-1:0] dist_dn;

    assign target  = {stop_angle_i, {FRAC_W{1'b0}}};
    // Modular distance to the target measured along each direction of travel.
    assign dist_up = target - acc_i;
    assign dist_dn = acc_i - target;
    assign hit_o   = step_i[ACC_W-1] ? (dist_dn <= mag_i) : (dist_up <= mag_i);

endmodule

// File: rtl/rotgen_ctrl.sv
module rotgen_ctrl
    import rotgen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rot_op_e op_i,
    input  logic    finish_i,
    output logic    running_o
);
    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            unique case (op_i)
                OP_LOAD,
                OP_HALT:  run_q <= 1'b0;
                OP_START: run_q <= 1'b1;
                OP_STEP:  run_q <= ~finish_i;
                default:  run_q <= run_q;
            endcase
        end
    end

    assign running_o = run_q;

    // R3: a start that is not overridden begins rotation
    p_start_runs_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_START) |=> run_q);

    // R9: a halt ends rotation
    p_halt_idles_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_HALT) |=> !run_q);

endmodule

// File: rtl/rotgen_accum.sv
module rotgen_accum
    import rotgen_pkg::*;
#(
    parameter int ANG_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  rot_op_e                 op_i,
    input  logic                    clamp_i,
    input  logic [ANG_W-1:0]        load_angle_i,
    input  logic [ANG_W-1:0]        stop_angle_i,
    input  logic [ANG_W+FRAC_W-1:0] step_i,
    output logic [ANG_W+FRAC_W-1:0] acc_o
);
    localparam int ACC_W = ANG_W + FRAC_W;

    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            unique case (op_i)
                OP_LOAD: acc_q <= {load_angle_i, {FRAC_W{1'b0}}};
                OP_STEP: acc_q <= clamp_i ? {stop_angle_i, {FRAC_W{1'b0}}}
                                          : acc_q + step_i;
                default: acc_q <= acc_q;
            endcase
        end
    end

    assign acc_o = acc_q;

    // R2: a load places the written angle with a clean fraction
    p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_LOAD) |=> acc_q == {$past(load_angle_i), {FRAC_W{1'b0}}});

    // R8: a clamping step lands exactly on the target
    p_clamp_exact_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_STEP && clamp_i) |=> acc_q[ACC_W-1:FRAC_W] == $past(stop_angle_i));

endmodule

// File: rtl/rotgen.sv
module rotgen
    import rotgen_pkg::*;
#(
    parameter int ANG_W      = 16,
    parameter int FRAC_W     = 8,
    parameter int RATE_W     = 16,
    parameter int RATE_LIMIT = RATE_LIMIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [ANG_W-1:0]  stop_angle_i,
    input  logic              cont_mode_i,
    input  logic              start_i,
    input  logic              halt_i,
    input  logic              load_i,
    input  logic [ANG_W-1:0]  load_angle_i,
    output logic [ANG_W-1:0]  angle_o,
    output logic              done_o
);
    localparam int ACC_W = ANG_W + FRAC_W;

    rot_req_t         req;
    rot_op_e          op;
    logic             running;
    logic             hit;
    logic             clamp;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] acc;

    assign req   = '{load: load_i, halt: halt_i, start: start_i, tick: tick_i};
    assign op    = decode_op(req, running);
    assign clamp = hit & ~cont_mode_i;

    rotgen_rate_sat #(
        .RATE_W    (RATE_W),
        .ACC_W     (ACC_W),
        .RATE_LIMIT(RATE_LIMIT)
    ) u_rate (
        .clk   (clk),
        .rst   (rst),
        .rate_i(rate_i),
        .step_o(step),
        .mag_o (mag)
    );

    rotgen_stop_det #(
        .ANG_W (ANG_W),
        .FRAC_W(FRAC_W)
    ) u_stop (
        .acc_i       (acc),
        .step_i      (step),
        .mag_i       (mag),
        .stop_angle_i(stop_angle_i),
        .hit_o       (hit)
    );

    rotgen_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .finish_i (clamp),
        .running_o(running)
    );

    rotgen_accum #(
        .ANG_W (ANG_W),
        .FRAC_W(FRAC_W)
    ) u_acc (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op),
        .clamp_i     (clamp),
        .load_angle_i(load_angle_i),
        .stop_angle_i(stop_angle_i),
        .step_i      (step),
        .acc_o       (acc)
    );

    assign angle_o = acc[ACC_W-1:FRAC_W];
    assign done_o  = ~running;

    // R11: no movement while finished unless loaded or restarted
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load_i && !start_i) |=> $stable(angle_o));

    // R7: continuous rotation never completes on a tick
    p_cont_no_done_r7: assert property (@(posedge clk) disable iff (rst)
        (!done_o && cont_mode_i && tick_i && !halt_i && !load_i && !start_i) |=> !done_o);

    // R2: a load always leaves the channel finished
    p_load_done_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> done_o);

    // R9: halt freezes the angle
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (halt_i && !load_i) |=> (done_o && $stable(angle_o)));

endmodule

// File: tb/test_rotgen.sv
module test_rotgen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [15:0] rate_i = '0;
    logic [15:0] stop_angle_i = '0;
    logic        cont_mode_i = 1'b0;
    logic        start_i = 1'b0;
    logic        halt_i = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] load_angle_i = '0;
    logic [15:0] angle_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rotgen i_rotgen (
        .clk(clk), .rst(rst), .tick_i(tick_i), .rate_i(rate_i),
        .stop_angle_i(stop_angle_i), .cont_mode_i(cont_mode_i),
        .start_i(start_i), .halt_i(halt_i), .load_i(load_i),
        .load_angle_i(load_angle_i), .angle_o(angle_o), .done_o(done_o)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock with the given pulses, driven from a falling edge.
    task automatic cyc(bit t, bit s, bit h, bit l);
        tick_i = t; start_i = s; halt_i = h; load_i = l;
        @(posedge clk);
        @(negedge clk);
        tick_i = 0; start_i = 0; halt_i = 0; load_i = 0;
    endtask

    task automatic load(logic [15:0] a);
        load_angle_i = a;
        cyc(0, 0, 0, 1);
    endtask

    task automatic t_reset();
        check("R1 angle", angle_o, 16'h0000);
        check("R1 done", {15'b0, done_o}, 16'h0001);
    endtask

    task automatic t_load_start();
        load(16'h1000);
        check("R2 angle", angle_o, 16'h1000);
        check("R2 done", {15'b0, done_o}, 16'h0001);
        rate_i = 16'h0100; cont_mode_i = 1;
        cyc(1, 1, 0, 0);
        check("R3 start no move", angle_o, 16'h1000);
        check("R3 done low", {15'b0, done_o}, 16'h0000);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
        check("R4 whole step", angle_o, 16'h1003);
        rate_i = 16'h0080;
        cyc(1, 0, 0, 0);
        check("R4 half step", angle_o, 16'h1003);
        cyc(1, 0, 0, 0);
        check("R4 carry", angle_o, 16'h1004);
    endtask

    task automatic t_negative();
        load(16'h0001);
        rate_i = 16'hFE00; cont_mode_i = 1;
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        check("R5 wrap down", angle_o, 16'hFFFF);
        cyc(1, 0, 0, 0);
        check("R5 further", angle_o, 16'hFFFD);
    endtask

    task automatic t_saturate();
        load(16'h0000);
        rate_i = 16'h7FFF; cont_mode_i = 1;
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        check("R6 positive limit", angle_o, 16'h007F);
        load(16'h0100);
        rate_i = 16'h8000;
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        check("R6 negative limit", angle_o, 16'h0080);
    endtask

    task automatic t_continuous();
        load(16'hFFFE);
        rate_i = 16'h0300; cont_mode_i = 1; stop_angle_i = 16'hFFFF;
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        check("R7 wrap past stop", angle_o, 16'h0001);
        check("R7 still running", {15'b0, done_o}, 16'h0000);
    endtask

    task automatic t_target();
        load(16'h0000);
        rate_i = 16'h0200; cont_mode_i = 0; stop_angle_i = 16'h0005;
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        check("R8 before target", angle_o, 16'h0004);
        check("R8 running", {15'b0, done_o}, 16'h0000);
        cyc(1, 0, 0, 0);
        check("R8 clamped", angle_o, 16'h0005);
        check("R8 done", {15'b0, done_o}, 16'h0001);
        cyc(1, 0, 0, 0);
        check("R11 tick ignored", angle_o, 16'h0005);
        // crossing through the wrap point
        load(16'hFFFC);
        rate_i = 16'h0400; stop_angle_i = 16'h0001;
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        check("R8 wrap approach", angle_o, 16'h0000);
        cyc(1, 0, 0, 0);
        check("R8 wrap clamp", angle_o, 16'h0001);
        check("R8 wrap done", {15'b0, done_o}, 16'h0001);
        // downward target
        load(16'h0010);
        rate_i = 16'hFD00; stop_angle_i = 16'h000C;
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        check("R8 down approach", angle_o, 16'h000D);
        cyc(1, 0, 0, 0);
        check("R8 down clamp", angle_o, 16'h000C);
        // resume from the completed angle in continuous mode
        cont_mode_i = 1;
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        check("R10 resume after completion", angle_o, 16'h0009);
    endtask

    task automatic t_halt();
        load(16'h2000);
        rate_i = 16'h0100; cont_mode_i = 1;
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        cyc(1, 0, 1, 0);
        check("R9 halt holds", angle_o, 16'h2001);
        check("R9 done", {15'b0, done_o}, 16'h0001);
        cyc(1, 0, 0, 0);
        check("R9 tick after halt", angle_o, 16'h2001);
        cyc(0, 1, 1, 0);
        check("R3 halt beats start", {15'b0, done_o}, 16'h0001);
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        check("R10 resume after halt", angle_o, 16'h2002);
        load_angle_i = 16'h3000;
        cyc(1, 1, 0, 1);
        check("R2 load wins angle", angle_o, 16'h3000);
        check("R2 load wins done", {15'b0, done_o}, 16'h0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_load_start();
        t_negative();
        t_saturate();
        t_continuous();
        t_target();
        t_halt();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule